// File: doc/BRIEF.md
# YCbCr 4:2:2 Input Demultiplexer

This block takes multiplexed 4:2:2 component video and turns it into one luma/blue-difference/red-difference triple per pixel on three parallel output channels. In the interleaved mode one bus carries every component in turn, with the clock at twice the pixel rate. In the split mode a luma bus and a chroma bus run side by side, with the clock at the pixel rate. A single-cycle strobe marks each finished triple.

The chroma phase is locked to the start of each line. That start comes from one of two sources: the first clock on which the horizontal sync input is high, or an embedded start-of-line code on the luma bus. An odd pixel has no chroma of its own, so it takes the chroma of the even pixel before it. In narrow operation only the upper bits of each bus are used, and the low output bits are driven to zero. The mode, sync-source and narrow selects are taken only between lines.

Top module: `ycc422_demux`

## Requirements
- R1: Interleaved mode: the words of a line arrive on `bus_a` as Cb, Y, Cr, Y. Each group of four words produces two pixels: Y from the second word, then Y from the fourth word, both with Cb from the first word and Cr from the third word.
- R2: Split mode: `bus_a` carries one Y per clock. `bus_b` carries Cb on the even word positions of the line (0, 2, ...) and Cr on the odd ones. Each pair of clocks produces pixels 2n and 2n+1.
- R3: Dedicated timing (`sel_embedded`=0): the first rising edge that sees `hs_in` high carries word 0 of the line, which is Cb. The line ends on the first edge that sees `hs_in` low.
- R4: Embedded timing: the word sequence all-ones, 0, 0, S on `bus_a` with S bit 4 = 0 is a start code, and the word after S is word 0. During a line, an all-ones word on `bus_a` ends the line. Code and status words never produce pixels.
- R5: An odd pixel's Cb and Cr outputs equal those of the even pixel that precedes it.
- R6: With `sel_narrow`=1, only bits [W-1:2] of each bus are used, and bits [1:0] of every output channel are 0.
- R7: The selects are taken only while no line is active. Changing them during a line has no effect on that line.
- R8: After synchronous reset, `pix_valid` is 0, all outputs are 0, and no `pix_valid` pulse occurs before the first line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_split | input | 1 | 1 = separate luma/chroma buses, 0 = single interleaved bus |
| sel_embedded | input | 1 | 1 = embedded line codes, 0 = `hs_in` timing |
| sel_narrow | input | 1 | 1 = use only the upper bits of each bus |
| hs_in | input | 1 | Horizontal sync, high during the active line |
| bus_a | input | W | Interleaved bus, or luma bus in split mode |
| bus_b | input | W | Chroma bus in split mode |
| pix_valid | output | 1 | One-cycle strobe per completed triple |
| out_g | output | W | Luma channel |
| out_b | output | W | Cb channel |
| out_r | output | W | Cr channel |

## Verification
The bench builds the block at its default W=10. It sweeps all eight combinations of split/interleaved, sync-input/embedded and full/narrow, with two lines per combination, so every word phase in both bus layouts is exercised. Pixel values come from arithmetic sequences that never form a code word. The expected triples are therefore computed from the pixel index alone, including the chroma held for odd pixels and the low bits cleared in narrow operation. Extra lines flip every select in the middle of a line, and a stretch of data with sync low follows reset to show that no output appears before a line start.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  typedef struct packed {
    logic split;
    logic emb;
    logic narrow;
  } ycc_cfg_t;

  // Bits of a bus word that carry data; narrow drops the lowest w-nb bits.
  function automatic logic [15:0] keep_mask(input int w, input int nb, input logic narrow);
    logic [15:0] m;
    m = 16'((32'd1 << w) - 1);
    if (narrow) m = m & ~16'((32'd1 << (w - nb)) - 1);
    return m;
  endfunction

endpackage

// File: rtl/ycc_cfg_latch.sv
module ycc_cfg_latch
  import ycc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     line_active,
  input  ycc_cfg_t cfg_in,
  output ycc_cfg_t cfg_eff
);
  ycc_cfg_t cfg_q;

  // Pins pass through between lines; the held copy rules during a line.
  assign cfg_eff = line_active ? cfg_q : cfg_in;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_in;
    else     cfg_q <= cfg_eff;
  end
endmodule

// File: rtl/ycc_line_track.sv
module ycc_line_track #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         split,
  input  logic         emb,
  input  logic         hs_in,
  input  logic [W-1:0] a_m,
  input  logic [W-1:0] msk,
  output logic         active,
  output logic         proc,
  output logic [1:0]   idx,
  output logic         sav_hit
);
  logic       d1o, d2o, d3o, d1z, d2z;
  logic [1:0] ph_q;
  logic       ones, zero;

  assign ones    = (a_m == msk);
  assign zero    = (a_m == '0);
  assign sav_hit = emb && !active && d3o && d2z && d1z && !a_m[4];
  assign proc    = emb ? (active && !ones) : hs_in;
  assign idx     = active ? ph_q : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      {d1o, d2o, d3o, d1z, d2z} <= '0;
      active <= 1'b0;
      ph_q   <= 2'd0;
    end else begin
      d1o <= ones; d2o <= d1o; d3o <= d2o;
      d1z <= zero; d2z <= d1z;
      active <= emb ? (sav_hit | (active & !ones)) : hs_in;
      ph_q   <= proc ? idx + 2'd1 : 2'd0;
    end
  end

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (proc && $past(proc) && active && $past(active) && !split) |-> idx == $past(idx) + 2'd1);
  // R3
  hs_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!emb && !active && hs_in) |=> (active && idx == 2'd1));
  // R4
  sav_start_chk: assert property (@(posedge clk) disable iff (rst)
    sav_hit |=> (active && idx == 2'd0));
endmodule

// File: rtl/ycc_pixel_pack.sv
module ycc_pixel_pack #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         split,
  input  logic         narrow,
  input  logic         proc,
  input  logic [1:0]   idx,
  input  logic [W-1:0] a_m,
  input  logic [W-1:0] b_m,
  output logic         valid,
  output logic [W-1:0] oy,
  output logic [W-1:0] ocb,
  output logic [W-1:0] ocr
);
  logic [W-1:0] y_h, cb_h, yodd;
  logic         pend, odd, nar_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      {y_h, cb_h, yodd, oy, ocb, ocr} <= '0;
      {pend, odd, valid, nar_q} <= '0;
    end else begin
      valid <= 1'b0;
      if (pend) begin
        oy <= yodd; valid <= 1'b1; odd <= 1'b1; pend <= 1'b0;
      end
      if (proc) begin
        nar_q <= narrow;
        if (!split) begin
          unique case (idx)
            2'd0: cb_h <= a_m;
            2'd1: y_h  <= a_m;
            2'd2: begin
              oy <= y_h; ocb <= cb_h; ocr <= a_m; valid <= 1'b1; odd <= 1'b0;
            end
            default: begin
              oy <= a_m; valid <= 1'b1; odd <= 1'b1;
            end
          endcase
        end else if (!idx[0]) begin
          cb_h <= b_m; y_h <= a_m;
        end else begin
          oy <= y_h; ocb <= cb_h; ocr <= b_m; yodd <= a_m;
          pend <= 1'b1; valid <= 1'b1; odd <= 1'b0;
        end
      end
    end
  end

  // R5
  odd_chroma_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && odd) |-> ($stable(ocb) && $stable(ocr)));
  // R6
  narrow_low_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && nar_q) |-> (oy[1:0] == 2'b00 && ocb[1:0] == 2'b00 && ocr[1:0] == 2'b00));
endmodule

// File: rtl/ycc422_demux.sv
module ycc422_demux
  import ycc_pkg::*;
#(
  parameter int W  = 10,
  parameter int NB = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_split,
  input  logic         sel_embedded,
  input  logic         sel_narrow,
  input  logic         hs_in,
  input  logic [W-1:0] bus_a,
  input  logic [W-1:0] bus_b,
  output logic         pix_valid,
  output logic [W-1:0] out_g,
  output logic [W-1:0] out_b,
  output logic [W-1:0] out_r
);
  ycc_cfg_t     cfg_in, cfg;
  logic         line_active, proc, sav_hit, started_q;
  logic [1:0]   idx;
  logic [W-1:0] msk, a_m, b_m;

  assign cfg_in = '{split: sel_split, emb: sel_embedded, narrow: sel_narrow};
  assign msk    = W'(keep_mask(W, NB, cfg.narrow));
  assign a_m    = bus_a & msk;
  assign b_m    = bus_b & msk;

  ycc_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .line_active(line_active), .cfg_in(cfg_in), .cfg_eff(cfg)
  );

  ycc_line_track #(.W(W)) u_trk (
    .clk(clk), .rst(rst), .split(cfg.split), .emb(cfg.emb), .hs_in(hs_in),
    .a_m(a_m), .msk(msk), .active(line_active), .proc(proc), .idx(idx), .sav_hit(sav_hit)
  );

  ycc_pixel_pack #(.W(W)) u_pack (
    .clk(clk), .rst(rst), .split(cfg.split), .narrow(cfg.narrow), .proc(proc), .idx(idx),
    .a_m(a_m), .b_m(b_m), .valid(pix_valid), .oy(out_g), .ocb(out_b), .ocr(out_r)
  );

  always_ff @(posedge clk) begin
    if (rst) started_q <= 1'b0;
    else     started_q <= started_q | line_active;
  end

  // R8
  no_early_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    !started_q |-> !pix_valid);
endmodule

// File: tb/sim_ycc422_demux.sv
module sim_ycc422_demux;
  localparam int W = 10;

  logic clk = 0, rst = 1;
  logic sel_split = 0, sel_embedded = 0, sel_narrow = 0, hs_in = 0;
  logic [W-1:0] bus_a = 10'h040, bus_b = 10'h200;
  logic pix_valid;
  logic [W-1:0] out_g, out_b, out_r;

  int n_cmp = 0, n_bad = 0, npix_seen = 0;
  logic [3*W:0] expq[$];
  string cur_tag = "R8";
  bit done = 0;

  always #5 clk = ~clk;

  ycc422_demux u0 (.*);

  function automatic logic [W-1:0] yv(int n);  return W'(64 + (n * 37) % 800);  endfunction
  function automatic logic [W-1:0] cbv(int n); return W'(100 + (n * 53) % 700); endfunction
  function automatic logic [W-1:0] crv(int n); return W'(150 + (n * 29) % 700); endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: outputs change at posedge, sampled at negedge.
  always @(negedge clk) begin
    if (!rst && pix_valid) begin
      npix_seen++;
      if (expq.size() == 0) chk(0, {cur_tag, " R8 unexpected pixel"}, int'(out_g), 0);
      else begin
        logic [3*W:0] e;
        e = expq.pop_front();
        chk(out_g == e[3*W-1:2*W], {cur_tag, " Y"}, int'(out_g), int'(e[3*W-1:2*W]));
        chk(out_b == e[2*W-1:W], {cur_tag, e[3*W] ? " R5 Cb" : " Cb"}, int'(out_b), int'(e[2*W-1:W]));
        chk(out_r == e[W-1:0], {cur_tag, e[3*W] ? " R5 Cr" : " Cr"}, int'(out_r), int'(e[W-1:0]));
      end
    end
  end

  task automatic drive(input logic h, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    hs_in = h; bus_a = a; bus_b = b;
  endtask

  task automatic send_line(input bit sp, input bit em, input bit nr, input int np,
                           input int base, input bit mc);
    logic [W-1:0] m, a, b;
    int nw;
    m = nr ? 10'h3FC : 10'h3FF;
    @(negedge clk);
    sel_split = sp; sel_embedded = em; sel_narrow = nr;
    cur_tag = $sformatf("%s %s%s%s", sp ? "R2" : "R1", em ? "R4" : "R3",
                        nr ? " R6" : "", mc ? " R7" : "");
    for (int p = 0; p < np; p++)
      expq.push_back({p[0], m & yv(base + p), m & cbv(base + (p & ~1)), m & crv(base + (p & ~1))});
    for (int i = 0; i < 3; i++) drive(0, 10'h040, 10'h200);
    if (em) begin
      drive(0, 10'h3FF, 10'h200); drive(0, 10'h000, 10'h200);
      drive(0, 10'h000, 10'h200); drive(0, 10'h200, 10'h200);
    end
    nw = sp ? np : 2 * np;
    for (int k = 0; k < nw; k++) begin
      if (sp) begin
        a = yv(base + k);
        b = k[0] ? crv(base + k - 1) : cbv(base + k);
      end else begin
        int e;
        e = base + 2 * (k / 4);
        case (k % 4)
          0: a = cbv(e);
          1: a = yv(e);
          2: a = crv(e);
          default: a = yv(e + 1);
        endcase
        b = 10'h155;
      end
      drive(!em, a, b);
      if (mc && k == 2) begin
        sel_split = !sp; sel_embedded = !em; sel_narrow = !nr;
      end
    end
    if (em) begin
      drive(0, 10'h3FF, 10'h200); drive(0, 10'h000, 10'h200);
      drive(0, 10'h000, 10'h200); drive(0, 10'h274, 10'h200);
    end
    for (int i = 0; i < 4; i++) drive(0, 10'h040, 10'h200);
    sel_split = sp; sel_embedded = em; sel_narrow = nr;
    chk(expq.size() == 0, {cur_tag, " line pixel count"}, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    chk(pix_valid == 0, "R8 valid after reset", int'(pix_valid), 0);
    chk(out_g == 0 && out_b == 0 && out_r == 0, "R8 outputs after reset", int'(out_g | out_b | out_r), 0);
    // R8 data without any line start yields nothing
    for (int i = 0; i < 20; i++) drive(0, W'(100 + i), W'(300 + i));
    chk(npix_seen == 0, "R8 pixels before first start", npix_seen, 0);
    base = 0;
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 2; l++) begin
        send_line(c[0], c[1], c[2], 6 + 2 * l, base, 0);
        base += 11;
      end
    end
    // R7 selects flipped mid-line
    send_line(0, 0, 0, 8, 500, 1);
    send_line(1, 1, 0, 8, 600, 1);
    send_line(0, 1, 1, 6, 700, 1);
    send_line(1, 0, 1, 6, 800, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule